// File: doc/BRIEF.md
# Scaled Saturating Pixel Pack Unit

This unit narrows fixed-point pixel lanes into smaller formats for display or storage. Each lane of the second operand is sign-extended, shifted left by a scale taken from a status word, shifted arithmetically right by a fixed binary-point amount that depends on the mode, and then clamped to the range of the target format. A two-bit mode code picks one of three conversions. The first packs four signed halfwords into unsigned bytes. The second packs two signed words into unsigned bytes and merges them into a shifted copy of the first operand, which acts as an accumulator. The third packs two signed words into signed halfwords.

One operation is accepted per clock when `in_valid` is high. The result appears, registered, on the next clock together with `out_valid`. A two-state controller tracks this. `ST_IDLE` goes to `ST_LOADED` when `in_valid` is high. `ST_LOADED` stays in `ST_LOADED` while `in_valid` remains high and returns to `ST_IDLE` when it is low. Reset forces `ST_IDLE`. `out_valid` is high exactly in `ST_LOADED`. The result register only loads when an operation is accepted and holds its value otherwise.

Top module: `pixel_pack_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. While `in_valid` is low, `result` keeps its previous value.
- R3: With mode code 0, the scale is `gsr[6:3]`. Each halfword lane i of `op_b` (bits 16i+15:16i, signed) is shifted left by the scale, shifted right by 7 (arithmetic) and clamped to 0..255. The clamped value goes to `result[8i+7:8i]`. `result[63:32]` is zero.
- R4: With mode code 0, `gsr[7]` and all `gsr` bits outside 6:3 have no effect on the result.
- R5: With mode code 1, the scale is `gsr[7:3]`. The result starts from `op_a` shifted left by 8, with bits 7:0 and 39:32 cleared. Each word lane w of `op_b` (bits 32w+31:32w, signed) is scaled, shifted right by 23 and clamped to 0..255, and the clamped value fills bits 32w+7:32w.
- R6: With mode code 2, the scale is `gsr[7:3]`. Each word lane w of `op_b` is scaled, shifted right by 16 and clamped to -32768..32767. Its low 16 bits go to `result[16w+15:16w]`. `result[63:32]` is zero.
- R7: Mode code 3 produces a result of zero.
- R8: The scaling is done at 64-bit width, so a large scale saturates rather than wraps. For example, mode 2 with scale 31 and lane value 1 gives 32767.
- R9: In modes 0 and 1, any lane whose shifted value is negative produces byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept an operation this cycle |
| mode | input | 2 | 0 halfword-to-byte, 1 word-to-byte merge, 2 word-to-halfword, 3 zero |
| gsr | input | 64 | Status word; the scale field is in bits 7:3 |
| op_a | input | 64 | Accumulator operand for mode 1 |
| op_b | input | 64 | Lanes to be packed |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Packed result |

## Verification
If the controller is stuck in the wrong state, `out_valid` disagrees with the delayed `in_valid` on the very next cycle. A result register that loads during idle cycles shows up as a changed `result` on the first cycle with `in_valid` low. Errors in the shift or clamp data path are visible one cycle after the operation is accepted. To catch them, the bench sweeps every scale value with lanes placed just inside and just outside each saturation limit. An off-by-one in the binary-point shift, or a clamp that wraps, therefore flips a byte at the boundary.

// File: rtl/pixel_pack_pkg.sv
package pixel_pack_pkg;

    typedef enum logic [1:0] {
        MODE_H2B   = 2'd0,
        MODE_W2B   = 2'd1,
        MODE_W2H   = 2'd2,
        MODE_NONE  = 2'd3
    } pack_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } pack_state_e;

    localparam int DATA_W   = 64;
    localparam int SCALE_W  = 5;
    localparam int H_LANES  = 4;
    localparam int W_LANES  = 2;
    localparam int H_FRAC   = 7;
    localparam int WB_FRAC  = 23;
    localparam int WH_FRAC  = 16;

endpackage

// File: rtl/pack_lane.sv
module pack_lane #(
    parameter int     IN_W  = 16,
    parameter int     FRAC  = 7,
    parameter int     OUT_W = 8,
    parameter longint LO    = 0,
    parameter longint HI    = 255
) (
    input  logic signed [IN_W-1:0] lane,
    input  logic [4:0]             scale,
    output logic [OUT_W-1:0]       packed_val
);
    localparam int WIDE_W = 64;
    localparam logic signed [WIDE_W-1:0] LO_W = LO;
    localparam logic signed [WIDE_W-1:0] HI_W = HI;

    logic signed [WIDE_W-1:0] widened;
    logic signed [WIDE_W-1:0] scaled;
    logic signed [WIDE_W-1:0] pointed;
    logic signed [WIDE_W-1:0] clamped;

    always_comb begin
        widened = WIDE_W'(lane);
        scaled  = widened <<< scale;
        pointed = scaled >>> FRAC;
        if (pointed < LO_W) begin
            clamped = LO_W;
        end else if (pointed > HI_W) begin
            clamped = HI_W;
        end else begin
            clamped = pointed;
        end
    end

    assign packed_val = clamped[OUT_W-1:0];
endmodule

// File: rtl/pixel_pack_unit.sv
module pixel_pack_unit
    import pixel_pack_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  mode,
    input  logic [63:0] gsr,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    output logic        out_valid,
    output logic [63:0] result
);
    localparam int H_W = DATA_W / H_LANES;
    localparam int W_W = DATA_W / W_LANES;

    pack_state_e state_q, state_d;
    pack_mode_e  mode_sel;
    logic [SCALE_W-1:0] scale_h, scale_w;
    logic [7:0]  h2b_byte [H_LANES];
    logic [7:0]  w2b_byte [W_LANES];
    logic [15:0] w2h_half [W_LANES];
    logic [63:0] next_res;
    logic        unused_bits;

    assign mode_sel    = pack_mode_e'(mode);
    assign scale_h     = {1'b0, gsr[6:3]};
    assign scale_w     = gsr[7:3];
    assign unused_bits = ^{gsr[63:8], gsr[2:0], op_a[63:56], op_a[31:24]};

    genvar gi;
    generate
        for (gi = 0; gi < H_LANES; gi++) begin : g_half
            pack_lane #(.IN_W(H_W), .FRAC(H_FRAC), .OUT_W(8), .LO(0), .HI(255)) u_lane (
                .lane       (op_b[gi*H_W +: H_W]),
                .scale      (scale_h),
                .packed_val (h2b_byte[gi])
            );
        end
        for (gi = 0; gi < W_LANES; gi++) begin : g_word
            pack_lane #(.IN_W(W_W), .FRAC(WB_FRAC), .OUT_W(8), .LO(0), .HI(255)) u_byte (
                .lane       (op_b[gi*W_W +: W_W]),
                .scale      (scale_w),
                .packed_val (w2b_byte[gi])
            );
            pack_lane #(.IN_W(W_W), .FRAC(WH_FRAC), .OUT_W(16), .LO(-32768), .HI(32767)) u_half (
                .lane       (op_b[gi*W_W +: W_W]),
                .scale      (scale_w),
                .packed_val (w2h_half[gi])
            );
        end
    endgenerate

    // Result selection per mode
    always_comb begin
        next_res = '0;
        unique case (mode_sel)
            MODE_H2B: begin
                for (int i = 0; i < H_LANES; i++) begin
                    next_res[8*i +: 8] = h2b_byte[i];
                end
            end
            MODE_W2B: begin
                next_res = {op_a[55:32], w2b_byte[1], op_a[23:0], w2b_byte[0]};
            end
            MODE_W2H: begin
                for (int i = 0; i < W_LANES; i++) begin
                    next_res[16*i +: 16] = w2h_half[i];
                end
            end
            MODE_NONE: next_res = '0;
        endcase
    end

    // Controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_IDLE;
        endcase
    end

    // Controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Controller: outputs
    always_comb begin
        out_valid = (state_q == ST_LOADED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_valid) begin
            result <= next_res;
        end
    end
endmodule

// File: rtl/pixel_pack_checker.sv
module pixel_pack_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  mode,
    input logic [23:0] op_a_lo,
    input logic        op_b_s0,
    input logic        out_valid,
    input logic [63:0] result
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    assert_h2b_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd0) |=> result[63:32] == 32'd0);

    assert_w2b_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd1) |=> result[31:8] == $past(op_a_lo));

    assert_w2h_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd2) |=> result[63:32] == 32'd0);

    assert_none_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd3) |=> result == 64'd0);

    assert_negative_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd0 && op_b_s0) |=> result[7:0] == 8'd0);
endmodule

bind pixel_pack_unit pixel_pack_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .op_a_lo   (op_a[23:0]),
    .op_b_s0   (op_b[15]),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/pixel_pack_unit_tb.sv
`timescale 1ns/1ps
module pixel_pack_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [63:0] gsr = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int    n_run = 0;
    int    n_fail = 0;
    bit    checking = 1'b0;
    bit    finished = 1'b0;
    string cur_tag = "R3";
    logic        exp_valid;
    logic [63:0] exp_res;
    string       exp_tag;

    always #2 clk = ~clk;

    pixel_pack_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .gsr(gsr), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result)
    );

    function automatic longint sat(longint v, int sc, int frac, longint lo, longint hi);
        longint t;
        t = (v <<< sc) >>> frac;
        if (t < lo) return lo;
        if (t > hi) return hi;
        return t;
    endfunction

    function automatic logic [63:0] model(logic [1:0] m, logic [63:0] g, logic [63:0] a, logic [63:0] b);
        logic [63:0] r;
        longint t;
        r = '0;
        case (m)
            2'd0: for (int i = 0; i < 4; i++) begin
                t = sat(longint'($signed(b[16*i +: 16])), int'(g[6:3]), 7, 0, 255);
                r[8*i +: 8] = t[7:0];
            end
            2'd1: begin
                r = (a << 8) & ~64'h000000ff000000ff;
                for (int w = 0; w < 2; w++) begin
                    t = sat(longint'($signed(b[32*w +: 32])), int'(g[7:3]), 23, 0, 255);
                    r[32*w +: 8] = t[7:0];
                end
            end
            2'd2: for (int w = 0; w < 2; w++) begin
                t = sat(longint'($signed(b[32*w +: 32])), int'(g[7:3]), 16, -32768, 32767);
                r[16*w +: 16] = t[15:0];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    // Reference model, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_res   <= '0;
            exp_tag   <= "R1";
        end else if (in_valid) begin
            exp_valid <= 1'b1;
            exp_res   <= model(mode, gsr, op_a, op_b);
            exp_tag   <= cur_tag;
        end else begin
            exp_valid <= 1'b0;
            exp_tag   <= "R2";
        end
    end

    always @(negedge clk) begin
        if (checking && !finished) begin
            n_run++;
            if (out_valid !== exp_valid || result !== exp_res) begin
                n_fail++;
                $display("FAIL %s: out_valid=%b result=%h expected out_valid=%b result=%h",
                         exp_tag, out_valid, result, exp_valid, exp_res);
            end
        end
    end

    task automatic drive(input logic [1:0] m, input logic [63:0] g,
                         input logic [63:0] a, input logic [63:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1; mode = m; gsr = g; op_a = a; op_b = b; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_b = {$urandom, $urandom};
            mode = 2'($urandom);
        end
    endtask

    initial begin
        @(posedge clk);
        checking = 1'b1;               // R1 checked during reset cycles
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);                        // R1/R2: still zero after reset

        for (int sc = 0; sc < 16; sc++) begin : sweep_h2b
            logic [15:0] l0, l1;
            l0 = 16'((longint'(255) << 7) >>> sc);
            l1 = 16'((longint'(256) << 7) >>> sc);
            drive(2'd0, 64'(sc) << 3, '0, {16'h8000, 16'hFFFF, l1, l0}, "R3");
            drive(2'd0, (64'(sc) << 3) | 64'hFFFF_FF00_0000_0087, '0,
                  {l0, l1, 16'h0080, 16'hFFFF}, "R4");
            drive(2'd0, 64'(sc) << 3, '0, {$urandom, $urandom}, "R9");
        end
        idle(3);                        // R2: result held
        for (int sc = 0; sc < 32; sc++) begin : sweep_w2b
            logic [31:0] l0, l1;
            l0 = 32'((longint'(255) << 23) >>> sc);
            l1 = 32'((longint'(256) << 23) >>> sc);
            drive(2'd1, 64'(sc) << 3, {$urandom, $urandom}, {l1, l0}, "R5");
            drive(2'd1, 64'(sc) << 3, {$urandom, $urandom}, {32'hFFFF_FFFF, l1}, "R9");
        end
        idle(2);
        for (int sc = 0; sc < 32; sc++) begin : sweep_w2h
            logic [31:0] l0, l1;
            l0 = 32'((longint'(32767) << 16) >>> sc);
            l1 = 32'((longint'(32768) << 16) >>> sc);
            drive(2'd2, 64'(sc) << 3, '0, {l1, l0}, "R6");
            drive(2'd2, 64'(sc) << 3, '0, {~l1 + 32'd1, ~l0}, "R6");
        end
        drive(2'd2, 64'd31 << 3, '0, {32'd1, 32'hFFFF_FFFF}, "R8");
        drive(2'd1, 64'd31 << 3, '1, {32'd1, 32'd2}, "R8");
        drive(2'd0, 64'd15 << 3, '0, {16'd1, 16'd2, 16'd3, 16'd4}, "R8");
        for (int k = 0; k < 8; k++) begin
            drive(2'd3, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, "R7");
        end
        idle(2);
        for (int k = 0; k < 200; k++) begin
            drive(2'($urandom_range(0, 2)), {$urandom, $urandom}, {$urandom, $urandom},
                  {$urandom, $urandom}, "R3");
            if (k % 7 == 0) idle(1);
        end
        idle(3);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule